// File: doc/BRIEF.md
# Command Recorder and Configuration Decoder

This block sits on a host command path and serves two write ports that behave differently. Writes on the recording port change no configuration. Each one carries a command class and a 5-bit code. The block keeps the newest code for every class in a small register file and presents all slots together as a status word. A downstream data generator samples that word to report which commands the host issued.

Writes on the configuration port are decoded. A 2-bit select is built from the top function-address bit and a data/control bit, and it steers the 5 data bits into one of four configuration registers, 20 bits in all. The decoded outputs are a 4-bit chip count with a single-cycle load pulse, a 7-bit word count, five mode flags and three spare bits. The spare bits are stored and visible at a port but drive nothing.

The two ports are fully independent and may both write in the same clock cycle.

Top module: `cmd_cfg_front`

## Requirements
- R1: A recording write (`rec_wr_i`=1) stores `rec_code_i` in slot `rec_cls_i`. From the following cycle it appears on `cmd_stat_o[5*cls+4 : 5*cls]`, and the other slots keep their values.
- R2: A recording write leaves `chip_cnt_o`, `word_cnt_o`, `mode_flags_o`, `spare_o` and `chip_cnt_ld_o` unchanged.
- R3: A configuration write leaves `cmd_stat_o` unchanged.
- R4: The select is {`cfg_hi_i`,`cfg_dsel_i`}. With select 00, a configuration write loads `chip_cnt_o` from `cfg_data_i[3:0]`. No other select changes `chip_cnt_o`.
- R5: A select-00 write with `cfg_data_i[4]`=1 raises `chip_cnt_ld_o` in the next cycle only. If `cfg_data_i[4]`=0, no pulse is produced. Back-to-back strobe writes give one high cycle per write.
- R6: A select-01 write loads `word_cnt_o[4:0]` from `cfg_data_i` and keeps `word_cnt_o[6:5]`.
- R7: A select-10 write loads `word_cnt_o[6:5]` from `cfg_data_i[1:0]` and `mode_flags_o[2:0]` from `cfg_data_i[4:2]`.
- R8: A select-11 write loads `mode_flags_o[4:3]` from `cfg_data_i[1:0]` and `spare_o` from `cfg_data_i[4:2]`.
- R9: In a cycle with no configuration write, every configuration output holds its value.
- R10: Reset clears all outputs to zero and holds `chip_cnt_ld_o` low.
- R11: A recording write and a configuration write in the same cycle both take full effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rec_wr_i | input | 1 | Recording port write strobe |
| rec_cls_i | input | 2 | Command class (slot index) |
| rec_code_i | input | 5 | Command code to record |
| cfg_wr_i | input | 1 | Configuration port write strobe |
| cfg_hi_i | input | 1 | Top function-address bit, select bit 1 |
| cfg_dsel_i | input | 1 | Data/control bit, select bit 0 |
| cfg_data_i | input | 5 | Configuration data |
| chip_cnt_o | output | 4 | Chip count |
| chip_cnt_ld_o | output | 1 | Chip count load pulse |
| word_cnt_o | output | 7 | Words per chip |
| mode_flags_o | output | 5 | Mode control flags |
| spare_o | output | 3 | Spare bits, stored only |
| cmd_stat_o | output | 20 | Recorded codes, slot 0 in the low bits |

## Verification
A recording write and a configuration write can land in the same cycle. Either one could then corrupt the other's state or be lost. The random phase enables both strobes independently on every cycle, so coincident writes to all slots and all selects occur often. A directed case also pairs a strobe write with a recording write. A reference model updates its status and configuration separately, and every output is compared one cycle after each write.

// File: rtl/cmd_cfg_pkg.sv
package cmd_cfg_pkg;
  typedef enum logic [1:0] {
    SEL_CHIP = 2'b00,
    SEL_WLO  = 2'b01,
    SEL_WHI  = 2'b10,
    SEL_AUX  = 2'b11
  } cfg_sel_e;
endpackage

// File: rtl/cmd_rst_sync.sv
module cmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cmd_recorder.sv
module cmd_recorder #(
  parameter int N_CLS  = 4,
  parameter int CODE_W = 5,
  localparam int CLS_W = $clog2(N_CLS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [CLS_W-1:0]        cls_i,
  input  logic [CODE_W-1:0]       code_i,
  output logic [N_CLS*CODE_W-1:0] stat_o
);
  logic [N_CLS-1:0] slot_en;

  for (genvar g = 0; g < N_CLS; g++) begin : g_slot
    logic [CODE_W-1:0] slot_q;
    logic [CODE_W-1:0] slot_d;

    assign slot_en[g] = wr_i && (cls_i == CLS_W'(g));

    always_comb begin
      slot_d = slot_q;
      if (slot_en[g]) slot_d = code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q <= '0;
      else if (slot_en[g]) slot_q <= slot_d;
    end

    assign stat_o[g*CODE_W +: CODE_W] = slot_q;
  end

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(stat_o)); // R3
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_en)); // R1
  AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cls_i == '0) |=> (stat_o[CODE_W-1:0] == $past(code_i))); // R1
endmodule

// File: rtl/cmd_cfg_regs.sv
module cmd_cfg_regs
  import cmd_cfg_pkg::*;
#(
  parameter int DATA_W = 5,
  parameter int NCH_W  = 4,
  parameter int NW_W   = 7,
  parameter int FLG_W  = 5,
  localparam int NW_HI_W  = NW_W - DATA_W,
  localparam int FLG_LO_W = DATA_W - NW_HI_W,
  localparam int FLG_HI_W = FLG_W - FLG_LO_W,
  localparam int SPR_W    = DATA_W - FLG_HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  cfg_sel_e          sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NCH_W-1:0]  chip_cnt_o,
  output logic              chip_ld_o,
  output logic [NW_W-1:0]   word_cnt_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic [SPR_W-1:0]  spare_o
);
  logic [NCH_W-1:0] nch_q, nch_d;
  logic             ld_q, ld_d;
  logic [NW_W-1:0]  nw_q, nw_d;
  logic [FLG_W-1:0] flg_q, flg_d;
  logic [SPR_W-1:0] spr_q, spr_d;
  logic             strobe_wr;

  assign strobe_wr = wr_i && (sel_i == SEL_CHIP) && data_i[DATA_W-1];

  always_comb begin
    nch_d = nch_q;
    nw_d  = nw_q;
    flg_d = flg_q;
    spr_d = spr_q;
    ld_d  = 1'b0;
    if (wr_i) begin
      unique case (sel_i)
        SEL_CHIP: begin
          nch_d = data_i[NCH_W-1:0];
          ld_d  = data_i[DATA_W-1];
        end
        SEL_WLO: nw_d[DATA_W-1:0] = data_i;
        SEL_WHI: begin
          nw_d[NW_W-1:DATA_W]  = data_i[NW_HI_W-1:0];
          flg_d[FLG_LO_W-1:0]  = data_i[DATA_W-1:NW_HI_W];
        end
        SEL_AUX: begin
          flg_d[FLG_W-1:FLG_LO_W] = data_i[FLG_HI_W-1:0];
          spr_d                   = data_i[DATA_W-1:FLG_HI_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nch_q <= '0;
      ld_q  <= 1'b0;
      nw_q  <= '0;
      flg_q <= '0;
      spr_q <= '0;
    end else begin
      ld_q <= ld_d;
      if (wr_i) begin
        nch_q <= nch_d;
        nw_q  <= nw_d;
        flg_q <= flg_d;
        spr_q <= spr_d;
      end
    end
  end

  assign chip_cnt_o = nch_q;
  assign chip_ld_o  = ld_q;
  assign word_cnt_o = nw_q;
  assign flags_o    = flg_q;
  assign spare_o    = spr_q;

  AST_LD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !strobe_wr) |=> !ld_q); // R5
  AST_LD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_wr |=> ld_q); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable({nch_q, nw_q, flg_q, spr_q})); // R9
  AST_WLO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_WLO) |=> $stable(nw_q[NW_W-1:DATA_W])); // R6
  AST_CHIP_ONLY_SEL0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i != SEL_CHIP) |=> $stable(nch_q)); // R4
  AST_AUX_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i != SEL_AUX) |=> $stable(spr_q)); // R8
endmodule

// File: rtl/cmd_cfg_front.sv
module cmd_cfg_front
  import cmd_cfg_pkg::*;
#(
  parameter int N_CLS  = 4,
  parameter int CODE_W = 5,
  parameter int DATA_W = 5,
  parameter int NCH_W  = 4,
  parameter int NW_W   = 7,
  parameter int FLG_W  = 5,
  localparam int CLS_W = $clog2(N_CLS),
  localparam int SPR_W = DATA_W - (FLG_W - (DATA_W - (NW_W - DATA_W)))
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rec_wr_i,
  input  logic [CLS_W-1:0]        rec_cls_i,
  input  logic [CODE_W-1:0]       rec_code_i,
  input  logic                    cfg_wr_i,
  input  logic                    cfg_hi_i,
  input  logic                    cfg_dsel_i,
  input  logic [DATA_W-1:0]       cfg_data_i,
  output logic [NCH_W-1:0]        chip_cnt_o,
  output logic                    chip_cnt_ld_o,
  output logic [NW_W-1:0]         word_cnt_o,
  output logic [FLG_W-1:0]        mode_flags_o,
  output logic [SPR_W-1:0]        spare_o,
  output logic [N_CLS*CODE_W-1:0] cmd_stat_o
);
  logic     rst_n_s;
  cfg_sel_e cfg_sel;

  assign cfg_sel = cfg_sel_e'({cfg_hi_i, cfg_dsel_i});

  cmd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cmd_recorder #(.N_CLS(N_CLS), .CODE_W(CODE_W)) u_rec (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_i   (rec_wr_i),
    .cls_i  (rec_cls_i),
    .code_i (rec_code_i),
    .stat_o (cmd_stat_o)
  );

  cmd_cfg_regs #(
    .DATA_W (DATA_W),
    .NCH_W  (NCH_W),
    .NW_W   (NW_W),
    .FLG_W  (FLG_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_i       (cfg_wr_i),
    .sel_i      (cfg_sel),
    .data_i     (cfg_data_i),
    .chip_cnt_o (chip_cnt_o),
    .chip_ld_o  (chip_cnt_ld_o),
    .word_cnt_o (word_cnt_o),
    .flags_o    (mode_flags_o),
    .spare_o    (spare_o)
  );

  AST_REC_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rec_wr_i && !cfg_wr_i) |=> $stable({chip_cnt_o, word_cnt_o, mode_flags_o, spare_o})); // R2
  AST_REC_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_wr_i |=> !chip_cnt_ld_o); // R2
  AST_CFG_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_wr_i && !rec_wr_i) |=> $stable(cmd_stat_o)); // R3
  AST_BOTH_SEL0: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rec_wr_i && cfg_wr_i && cfg_sel == SEL_CHIP) |=> (chip_cnt_o == $past(cfg_data_i[NCH_W-1:0]))); // R11
endmodule

// File: tb/cmd_cfg_front_tb.sv
`timescale 1ns/1ps
module cmd_cfg_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rec_wr, cfg_wr, cfg_hi, cfg_dsel;
  logic [1:0]  rec_cls;
  logic [4:0]  rec_code, cfg_data;
  logic [3:0]  chip_cnt;
  logic        chip_ld;
  logic [6:0]  word_cnt;
  logic [4:0]  flags;
  logic [2:0]  spare;
  logic [19:0] stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [19:0] m_stat;
  logic [3:0]  m_nch;
  logic        m_ld;
  logic [6:0]  m_nw;
  logic [4:0]  m_flg;
  logic [2:0]  m_spr;

  always #2.5 clk = ~clk;

  cmd_cfg_front dut_i (
    .clk(clk), .rst_n(rst_n),
    .rec_wr_i(rec_wr), .rec_cls_i(rec_cls), .rec_code_i(rec_code),
    .cfg_wr_i(cfg_wr), .cfg_hi_i(cfg_hi), .cfg_dsel_i(cfg_dsel), .cfg_data_i(cfg_data),
    .chip_cnt_o(chip_cnt), .chip_cnt_ld_o(chip_ld), .word_cnt_o(word_cnt),
    .mode_flags_o(flags), .spare_o(spare), .cmd_stat_o(stat)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] stat_next(logic [19:0] s, logic w, logic [1:0] c, logic [4:0] d);
    logic [19:0] r = s;
    if (w) r[c*5 +: 5] = d;
    return r;
  endfunction

  task automatic check_all(string tag);
    check({tag, " R1 stat"}, 32'(stat), 32'(m_stat));
    check({tag, " R4 chip_cnt"}, 32'(chip_cnt), 32'(m_nch));
    check({tag, " R5 ld"}, 32'(chip_ld), 32'(m_ld));
    check({tag, " R6 word_cnt"}, 32'(word_cnt), 32'(m_nw));
    check({tag, " R7 flags"}, 32'(flags), 32'(m_flg));
    check({tag, " R8 spare"}, 32'(spare), 32'(m_spr));
  endtask

  // Called at a negedge; applies one cycle of stimulus and checks at the next negedge.
  task automatic cyc(logic rw, logic [1:0] rc, logic [4:0] rd,
                     logic cw, logic ch, logic cd, logic [4:0] dd, string tag);
    rec_wr = rw; rec_cls = rc; rec_code = rd;
    cfg_wr = cw; cfg_hi = ch; cfg_dsel = cd; cfg_data = dd;
    m_stat = stat_next(m_stat, rw, rc, rd);
    m_ld = 1'b0;
    if (cw) begin
      case ({ch, cd})
        2'b00: begin m_nch = dd[3:0]; m_ld = dd[4]; end
        2'b01: m_nw[4:0] = dd;
        2'b10: begin m_nw[6:5] = dd[1:0]; m_flg[2:0] = dd[4:2]; end
        default: begin m_flg[4:3] = dd[1:0]; m_spr = dd[4:2]; end
      endcase
    end
    @(negedge clk);
    rec_wr = 1'b0; cfg_wr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    rec_wr = 0; cfg_wr = 0; rec_cls = 0; rec_code = 0;
    cfg_hi = 0; cfg_dsel = 0; cfg_data = 0;
    m_stat = '0; m_nch = '0; m_ld = 0; m_nw = '0; m_flg = '0; m_spr = '0;
    repeat (3) @(negedge clk);
    check_all("R10 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R10 after release");

    // R1 each slot, R2 config untouched
    for (int i = 0; i < 4; i++) cyc(1, 2'(i), 5'(5'h11 + i), 0, 0, 0, 0, "R1 R2 rec");
    // R4/R5 strobe write, then pulse gone
    cyc(0, 0, 0, 1, 0, 0, 5'b1_1010, "R4 R5 strobe");
    cyc(0, 0, 0, 0, 0, 0, 0, "R5 R9 idle after pulse");
    // R5 no pulse when bit4 clear
    cyc(0, 0, 0, 1, 0, 0, 5'b0_0110, "R5 no strobe");
    // R5 back-to-back
    cyc(0, 0, 0, 1, 0, 0, 5'b1_0001, "R5 b2b first");
    cyc(0, 0, 0, 1, 0, 0, 5'b1_0010, "R5 b2b second");
    cyc(0, 0, 0, 0, 0, 0, 0, "R5 b2b end");
    // R6 / R7 / R8 with R3 stat untouched
    cyc(0, 0, 0, 1, 1, 0, 5'b10111, "R7 R3 whi");
    cyc(0, 0, 0, 1, 0, 1, 5'b01100, "R6 R3 wlo");
    cyc(0, 0, 0, 1, 1, 1, 5'b11101, "R8 R3 aux");
    // R11 coincident writes incl. strobe
    cyc(1, 2, 5'h1f, 1, 0, 0, 5'b1_1111, "R11 both strobe");
    cyc(1, 3, 5'h02, 1, 1, 1, 5'b00010, "R11 both aux");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9 idle");

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[2:1], r[7:3], r[8], r[9], r[10], r[15:11], "R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule